// File: doc/BRIEF.md
# Programmable-Timing SPI Master

This block is the serial engine of an SPI controller in master mode. Words come in through a small transmit queue. For each word the engine lowers one active-low chip select and shifts the word out on the serial output while it captures the serial input on the opposite clock edge. When the frame ends it places the captured word in a receive queue. The frame length, clock polarity and phase, bit order, clock prescaler and divider, and three chip-select spacing delays are plain configuration inputs. The surrounding register file is expected to hold them steady while a transfer runs.

All timing is counted in ticks of a prescaled clock. A tick occurs once every 2^prescale functional-clock cycles. The state machine has five states. `ST_IDLE` waits with chip select high. `ST_LEAD` holds chip select low before the first clock edge. `ST_SHIFT` toggles the serial clock, with a phase flag that tells the active half from the idle half. `ST_TRAIL` holds chip select low after the last edge. `ST_GAP` keeps chip select high between frames. The transitions are:
- start: `ST_IDLE`→`ST_LEAD` when enabled, the transmit queue is not empty and the receive queue is not full.
- lead-done: `ST_LEAD`→`ST_SHIFT`.
- last-trailing-edge: `ST_SHIFT`→`ST_TRAIL`.
- trail-done: `ST_TRAIL`→`ST_GAP`.
- gap-done: `ST_GAP`→`ST_LEAD` when another word is ready, otherwise `ST_GAP`→`ST_IDLE`.
- disable: any state→`ST_IDLE`.

Two status flags report the queue levels against programmable watermarks. Each flag is cleared by writing a one to its clear bit.

Top module: `spi_master_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cs_n` is 1, `sck` equals `cfg_cpol`, `rx_empty` is 1, `tx_full` is 0, and both flags are 0.
- R2: Each frame carries `cfg_frame_len`+1 bits, and exactly one receive word is stored per frame. Received bits above the frame length read as zero.
- R3: With `cfg_lsb_first`=0 bit `cfg_frame_len` is sent first and bit 0 last. With `cfg_lsb_first`=1 the order is reversed. Received bits land at the same positions as the sent bits.
- R4: `sck` rests at `cfg_cpol` whenever `cs_n` is high. With `cfg_cpha`=0 the first bit is driven before the leading edge, data is captured on the leading edge and changes on the trailing edge. With `cfg_cpha`=1 data changes on the leading edge and is captured on the trailing edge.
- R5: One `sck` period lasts (`cfg_sck_div`+2) ticks, and a tick is 2^`cfg_prescale` clock cycles.
- R6: The first `sck` edge comes (`cfg_lead_dly`+1) ticks after `cs_n` falls. `cs_n` rises (`cfg_trail_dly`+1) ticks after the last `sck` edge.
- R7: Between two back-to-back frames `cs_n` stays high for exactly (`cfg_gap_dly`+2) ticks.
- R8: `sout` keeps its last driven value while `cs_n` is high.
- R9: `flag_tx` is set while the transmit queue holds no more than `cfg_tx_water` words. `flag_rx` is set while the receive queue holds more than `cfg_rx_water` words. A 1 on `flag_clear[0]` clears `flag_tx` and a 1 on `flag_clear[1]` clears `flag_rx`. A cleared flag stays clear until its condition holds again on a later cycle.
- R10: A frame never starts while the transmit queue is empty or the receive queue is full. The waiting word is kept and sent once space frees, so no data is lost.
- R11: No frame starts while `enable` is 0. Clearing `enable` during a frame raises `cs_n` and returns `sck` to idle on the next clock edge.
- R12: Each queue holds 4 words. A write to a full transmit queue is ignored, and `tx_full` reports that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_frame_len | input | 4 | Frame bits minus one |
| cfg_prescale | input | 3 | Tick = 2^value clocks |
| cfg_sck_div | input | 8 | SCK period minus two, in ticks |
| cfg_lead_dly | input | 8 | CS-to-first-edge delay minus one |
| cfg_trail_dly | input | 8 | Last-edge-to-CS-rise delay minus one |
| cfg_gap_dly | input | 8 | Inter-frame CS-high time minus two |
| cfg_tx_water | input | 2 | Transmit flag watermark |
| cfg_rx_water | input | 2 | Receive flag watermark |
| tx_wr | input | 1 | Push strobe for the transmit queue |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop strobe for the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| flag_clear | input | 2 | Write-one-to-clear: bit0 transmit flag, bit1 receive flag |
| flag_tx | output | 1 | Transmit watermark flag |
| flag_rx | output | 1 | Receive watermark flag |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |

## Verification
A wrong state or phase register shows at the pins within one tick. It appears as an `sck` edge at the wrong moment, a `cs_n` low period of the wrong length, or a bit count other than the frame length. The bench times each of these against edge timestamps. A bad bit-position counter shows up as a reordered or shifted word, both on the monitored `sout` stream and in the looped-back receive word, as soon as the frame completes. A wrong queue count appears within a cycle on `tx_full`, `rx_empty` or the watermark flags, or later as a frame that starts with a full receive queue or never starts.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } eng_state_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    localparam int PCNT_W = (1 << PRE_W) - 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] limit;

    assign limit = PCNT_W'((32'd1 << prescale) - 32'd1);
    assign tick  = run & (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pcnt <= '0;
        else if (!run)           pcnt <= '0;
        else if (pcnt == limit)  pcnt <= '0;
        else                     pcnt <= pcnt + PCNT_W'(1);
    end

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       tick,
    input  logic                       cfg_cpol,
    input  logic                       cfg_cpha,
    input  logic                       cfg_lsb_first,
    input  logic [$clog2(DATA_W)-1:0]  cfg_frame_len,
    input  logic [DLY_W-1:0]           cfg_sck_div,
    input  logic [DLY_W-1:0]           cfg_lead_dly,
    input  logic [DLY_W-1:0]           cfg_trail_dly,
    input  logic [DLY_W-1:0]           cfg_gap_dly,
    input  logic                       tx_empty,
    input  logic [DATA_W-1:0]          tx_head,
    output logic                       tx_pop,
    input  logic                       rx_full,
    output logic                       rx_push,
    output logic [DATA_W-1:0]          rx_word,
    output logic                       run,
    output logic                       sck,
    output logic                       cs_n,
    output logic                       sout,
    input  logic                       sin
);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int CNT_W = DLY_W + 2;

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  bidx;
    logic              sck_act;
    logic [DATA_W-1:0] tx_sh, rx_sh;

    logic [CNT_W-1:0]  period, half_act, half_idl;
    logic              lead_hit, trail_hit, gap_hit, act_hit, idl_hit;
    logic              ready, last_bit;
    logic              ev_start, ev_lead_edge, ev_trail_edge, ev_end_trail;
    logic [LEN_W-1:0]  pos_cur, pos_nxt, pos_first;

    // timing limits in ticks
    assign period    = CNT_W'(cfg_sck_div) + CNT_W'(2);
    assign half_act  = period >> 1;
    assign half_idl  = period - half_act;
    assign lead_hit  = (cnt == CNT_W'(cfg_lead_dly));
    assign trail_hit = (cnt == CNT_W'(cfg_trail_dly));
    assign gap_hit   = (cnt == CNT_W'(cfg_gap_dly) + CNT_W'(1));
    assign act_hit   = (cnt == half_act - CNT_W'(1));
    assign idl_hit   = (cnt == half_idl - CNT_W'(1));

    assign ready     = enable & ~tx_empty & ~rx_full;
    assign last_bit  = (bidx == cfg_frame_len);

    // bit positions for the selected order
    assign pos_cur   = cfg_lsb_first ? bidx : (cfg_frame_len - bidx);
    assign pos_nxt   = cfg_lsb_first ? (bidx + LEN_W'(1)) : (cfg_frame_len - bidx - LEN_W'(1));
    assign pos_first = cfg_lsb_first ? '0 : cfg_frame_len;

    // named events
    assign ev_start      = enable & (((state_q == ST_IDLE) & ready) |
                                     ((state_q == ST_GAP) & tick & gap_hit & ready));
    assign ev_lead_edge  = enable & tick & (((state_q == ST_LEAD) & lead_hit) |
                                            ((state_q == ST_SHIFT) & ~sck_act & idl_hit));
    assign ev_trail_edge = enable & tick & (state_q == ST_SHIFT) & sck_act & act_hit;
    assign ev_end_trail  = enable & tick & (state_q == ST_TRAIL) & trail_hit;

    assign tx_pop  = ev_start;
    assign rx_push = ev_end_trail;
    assign rx_word = rx_sh;
    assign run     = (state_q != ST_IDLE);
    assign sck     = cfg_cpol ^ sck_act;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ready) state_d = ST_LEAD;
            ST_LEAD:  if (tick && lead_hit) state_d = ST_SHIFT;
            ST_SHIFT: if (ev_trail_edge && last_bit) state_d = ST_TRAIL;
            ST_TRAIL: if (tick && trail_hit) state_d = ST_GAP;
            ST_GAP:   if (tick && gap_hit) state_d = ready ? ST_LEAD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bidx    <= '0;
            sck_act <= 1'b0;
            cs_n    <= 1'b1;
            sout    <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (!enable) begin
            cnt     <= '0;
            sck_act <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            if ((state_d != state_q) || ev_lead_edge || ev_trail_edge) cnt <= '0;
            else if (tick)                                            cnt <= cnt + CNT_W'(1);

            if (ev_start) begin
                cs_n  <= 1'b0;
                tx_sh <= tx_head;
                rx_sh <= '0;
                bidx  <= '0;
                if (!cfg_cpha) sout <= tx_head[pos_first];
            end

            if (ev_lead_edge) begin
                sck_act <= 1'b1;
                if (cfg_cpha) sout <= tx_sh[pos_cur];
                else          rx_sh[pos_cur] <= sin;
            end

            if (ev_trail_edge) begin
                sck_act <= 1'b0;
                if (cfg_cpha) rx_sh[pos_cur] <= sin;
                if (!last_bit) begin
                    bidx <= bidx + LEN_W'(1);
                    if (!cfg_cpha) sout <= tx_sh[pos_nxt];
                end
            end

            if (ev_end_trail) cs_n <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int PRE_W      = 3,
    parameter int DLY_W      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic                           cfg_cpol,
    input  logic                           cfg_cpha,
    input  logic                           cfg_lsb_first,
    input  logic [$clog2(DATA_W)-1:0]      cfg_frame_len,
    input  logic [PRE_W-1:0]               cfg_prescale,
    input  logic [DLY_W-1:0]               cfg_sck_div,
    input  logic [DLY_W-1:0]               cfg_lead_dly,
    input  logic [DLY_W-1:0]               cfg_trail_dly,
    input  logic [DLY_W-1:0]               cfg_gap_dly,
    input  logic [$clog2(FIFO_DEPTH)-1:0]  cfg_tx_water,
    input  logic [$clog2(FIFO_DEPTH)-1:0]  cfg_rx_water,
    input  logic                           tx_wr,
    input  logic [DATA_W-1:0]              tx_data,
    output logic                           tx_full,
    input  logic                           rx_rd,
    output logic [DATA_W-1:0]              rx_data,
    output logic                           rx_empty,
    input  logic [1:0]                     flag_clear,
    output logic                           flag_tx,
    output logic                           flag_rx,
    output logic                           sck,
    output logic                           cs_n,
    output logic                           sout,
    input  logic                           sin
);
    localparam int FCNT_W = $clog2(FIFO_DEPTH+1);

    logic              tx_empty, tx_pop, rx_full, rx_push, run, tick;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic [FCNT_W-1:0] tx_count, rx_count;

    spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .push_data(tx_data), .pop(tx_pop),
        .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word), .pop(rx_rd),
        .head(rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    spi_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .prescale(cfg_prescale), .tick(tick)
    );

    spi_shift_fsm #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_frame_len(cfg_frame_len), .cfg_sck_div(cfg_sck_div),
        .cfg_lead_dly(cfg_lead_dly), .cfg_trail_dly(cfg_trail_dly),
        .cfg_gap_dly(cfg_gap_dly),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .run(run), .sck(sck), .cs_n(cs_n), .sout(sout), .sin(sin)
    );

    // watermark flags, clear has priority for one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_tx <= 1'b0;
            flag_rx <= 1'b0;
        end else begin
            if (flag_clear[0])                             flag_tx <= 1'b0;
            else if (tx_count <= FCNT_W'(cfg_tx_water))    flag_tx <= 1'b1;
            if (flag_clear[1])                             flag_rx <= 1'b0;
            else if (rx_count > FCNT_W'(cfg_rx_water))     flag_rx <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_master_checker.sv
module spi_master_checker #(
    parameter int FIFO_DEPTH = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               enable,
    input logic                               cfg_cpol,
    input logic                               cs_n,
    input logic                               sck,
    input logic                               sout,
    input logic                               rx_empty,
    input logic [1:0]                         flag_clear,
    input logic                               flag_tx,
    input logic                               flag_rx,
    input logic [$clog2(FIFO_DEPTH+1)-1:0]    rx_count
);
    localparam int FCNT_W = $clog2(FIFO_DEPTH+1);

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cfg_cpol)); // R4

    AST_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(sout)); // R8

    AST_TX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_clear[0]) |-> !flag_tx); // R9

    AST_RX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag_clear[1]) |-> !flag_rx); // R9

    AST_NO_START_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(rx_count) != FCNT_W'(FIFO_DEPTH))); // R10

    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> cs_n); // R11

    AST_WORD_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_empty) |-> $rose(cs_n)); // R2

endmodule

bind spi_master_engine spi_master_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_cpol(cfg_cpol),
    .cs_n(cs_n), .sck(sck), .sout(sout), .rx_empty(rx_empty),
    .flag_clear(flag_clear), .flag_tx(flag_tx), .flag_rx(flag_rx),
    .rx_count(rx_count)
);

// File: tb/tb_spi_master_engine.sv
`timescale 1ns/1ps
module tb_spi_master_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_frame_len = 4'd7;
    logic [2:0]  cfg_prescale = 3'd0;
    logic [7:0]  cfg_sck_div = 8'd0, cfg_lead_dly = 8'd0, cfg_trail_dly = 8'd0, cfg_gap_dly = 8'd0;
    logic [1:0]  cfg_tx_water = 2'd0, cfg_rx_water = 2'd0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0;
    logic [15:0] tx_data = '0;
    logic [1:0]  flag_clear = 2'b00;
    logic        tx_full, rx_empty, flag_tx, flag_rx, sck, cs_n, sout, sin;
    logic [15:0] rx_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    assign sin = sout;   // loopback
    always #2 clk = ~clk;

    spi_master_engine dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_frame_len(cfg_frame_len), .cfg_prescale(cfg_prescale),
        .cfg_sck_div(cfg_sck_div), .cfg_lead_dly(cfg_lead_dly),
        .cfg_trail_dly(cfg_trail_dly), .cfg_gap_dly(cfg_gap_dly),
        .cfg_tx_water(cfg_tx_water), .cfg_rx_water(cfg_rx_water),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
        .flag_clear(flag_clear), .flag_tx(flag_tx), .flag_rx(flag_rx),
        .sck(sck), .cs_n(cs_n), .sout(sout), .sin(sin)
    );

    // pin monitor
    logic        sout_prev = 1'b0;
    logic        cs_prev = 1'b1, sck_prev = 1'b0;
    logic [31:0] mon_bits = '0;
    int          mon_n = 0, edge_n = 0;
    longint      t_csf = 0, t_csr = 0, t_e1 = 0, t_e3 = 0, t_last = 0, gap_meas = 0;

    always @(negedge clk) sout_prev <= sout;

    always @(sck, cs_n) begin
        if (cs_n !== cs_prev) begin
            if (cs_n === 1'b0) begin
                t_csf    = $time;
                gap_meas = $time - t_csr;
                edge_n   = 0;
                mon_n    = 0;
                mon_bits = '0;
            end else if (cs_n === 1'b1) begin
                t_csr = $time;
            end
            cs_prev = cs_n;
        end
        if (sck !== sck_prev) begin
            if (cs_n === 1'b0 && rst_n) begin
                edge_n++;
                if (edge_n == 1) t_e1 = $time;
                if (edge_n == 3) t_e3 = $time;
                t_last = $time;
                if ((sck != cfg_cpol) ^ cfg_cpha) begin
                    mon_bits = {mon_bits[30:0], sout_prev};
                    mon_n++;
                end
            end
            sck_prev = sck;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pop();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_rx();
        while (rx_empty) @(negedge clk);
    endtask

    task automatic fast_timing();
        cfg_prescale = 0; cfg_sck_div = 0; cfg_lead_dly = 0; cfg_trail_dly = 0; cfg_gap_dly = 0;
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        chk(sck == cfg_cpol, "R1 sck in reset", sck, cfg_cpol);
        chk(rx_empty == 1'b1 && tx_full == 1'b0, "R1 queues in reset", {rx_empty, tx_full}, 2'b10);
        chk(flag_tx == 1'b0 && flag_rx == 1'b0, "R1 flags in reset", {flag_tx, flag_rx}, 0);
    endtask

    task automatic t_frame(input logic pol, input logic pha, input logic lsb,
                           input logic [3:0] len, input logic [15:0] d);
        logic [15:0] mask, exp_mon;
        logic        last;
        @(negedge clk);
        enable = 0; fast_timing();
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_frame_len = len;
        push(d);
        enable = 1;
        wait_rx();
        mask = 16'hFFFF >> (15 - len);
        exp_mon = '0;
        for (int i = 0; i <= int'(len); i++)
            exp_mon = {exp_mon[14:0], lsb ? d[i] : d[int'(len) - i]};
        last = lsb ? d[len] : d[0];
        chk(rx_data == (d & mask), "R2 R3 received word", rx_data, d & mask);
        chk(mon_n == int'(len) + 1, "R2 bits per frame", mon_n, int'(len) + 1);
        chk(mon_bits[15:0] == exp_mon, "R3 R4 sout order at capture edges", mon_bits, exp_mon);
        repeat (5) @(negedge clk);
        chk(sck == pol, "R4 sck idle level", sck, pol);
        chk(sout == last, "R8 sout holds last bit", sout, last);
        pop();
        enable = 0;
    endtask

    task automatic t_timing();
        longint tk;
        @(negedge clk);
        enable = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_frame_len = 7;
        cfg_prescale = 1; cfg_sck_div = 3; cfg_lead_dly = 2; cfg_trail_dly = 3; cfg_gap_dly = 1;
        tk = 4 * 2;
        push(16'h00A5); push(16'h003C);
        enable = 1;
        wait_rx();
        chk(t_e1 - t_csf == 3 * tk, "R6 lead delay", t_e1 - t_csf, 3 * tk);
        chk(t_e3 - t_e1 == 5 * tk, "R5 sck period", t_e3 - t_e1, 5 * tk);
        chk(t_csr - t_last == 4 * tk, "R6 trail delay", t_csr - t_last, 4 * tk);
        chk(rx_data == 16'h00A5, "R2 first timed word", rx_data, 16'h00A5);
        pop();
        wait_rx();
        chk(gap_meas == 3 * tk, "R7 gap between frames", gap_meas, 3 * tk);
        chk(rx_data == 16'h003C, "R2 second timed word", rx_data, 16'h003C);
        pop();
        enable = 0;
    endtask

    task automatic t_flags();
        @(negedge clk);
        enable = 0; fast_timing(); cfg_frame_len = 7; cfg_tx_water = 0; cfg_rx_water = 1;
        @(negedge clk);
        chk(flag_tx == 1'b1, "R9 tx flag set on empty queue", flag_tx, 1);
        flag_clear = 2'b01; @(negedge clk); flag_clear = 2'b00;
        chk(flag_tx == 1'b0, "R9 tx flag cleared", flag_tx, 0);
        @(negedge clk);
        chk(flag_tx == 1'b1, "R9 tx flag re-sets", flag_tx, 1);
        push(16'h1111); push(16'h2222);
        flag_clear = 2'b01; @(negedge clk); flag_clear = 2'b00;
        repeat (3) @(negedge clk);
        chk(flag_tx == 1'b0, "R9 tx flag stays clear above water", flag_tx, 0);
        cfg_tx_water = 2;
        repeat (2) @(negedge clk);
        chk(flag_tx == 1'b1, "R9 tx flag at raised water", flag_tx, 1);
        enable = 1;
        repeat (120) @(negedge clk);
        chk(flag_rx == 1'b1, "R9 rx flag above water", flag_rx, 1);
        pop();
        flag_clear = 2'b10; @(negedge clk); flag_clear = 2'b00;
        repeat (3) @(negedge clk);
        chk(flag_rx == 1'b0, "R9 rx flag stays clear at water", flag_rx, 0);
        pop();
        enable = 0; cfg_tx_water = 0;
    endtask

    task automatic t_stall();
        @(negedge clk);
        enable = 1; fast_timing(); cfg_frame_len = 7; cfg_tx_water = 0;
        for (int i = 0; i < 5; i++) push(16'h0040 + 16'(i));
        repeat (300) @(negedge clk);
        chk(cs_n == 1'b1, "R10 no frame with full rx queue", cs_n, 1);
        flag_clear = 2'b01; @(negedge clk); flag_clear = 2'b00;
        repeat (2) @(negedge clk);
        chk(flag_tx == 1'b0, "R10 word kept in tx queue", flag_tx, 0);
        for (int i = 0; i < 5; i++) begin
            wait_rx();
            chk(rx_data == 16'h0040 + 16'(i), "R10 stalled data delivered in order", rx_data, 16'h0040 + i);
            pop();
        end
        enable = 0;
    endtask

    task automatic t_fifo_full();
        @(negedge clk);
        enable = 0; fast_timing(); cfg_frame_len = 15;
        for (int i = 0; i < 6; i++) push(16'h9000 + 16'(i));
        chk(tx_full == 1'b1, "R12 tx queue full after 4 words", tx_full, 1);
        enable = 1;
        for (int i = 0; i < 4; i++) begin
            wait_rx();
            chk(rx_data == 16'h9000 + 16'(i), "R12 first four words kept", rx_data, 16'h9000 + i);
            pop();
        end
        repeat (200) @(negedge clk);
        chk(rx_empty == 1'b1, "R12 writes to full queue dropped", rx_empty, 1);
        enable = 0;
    endtask

    task automatic t_enable();
        @(negedge clk);
        enable = 0; fast_timing(); cfg_frame_len = 7; cfg_cpol = 1;
        push(16'h0077);
        repeat (50) @(negedge clk);
        chk(cs_n == 1'b1 && rx_empty == 1'b1, "R11 no frame while disabled", {cs_n, rx_empty}, 2'b11);
        cfg_prescale = 2; cfg_sck_div = 8; cfg_lead_dly = 4;
        enable = 1;
        while (cs_n) @(negedge clk);
        repeat (40) @(negedge clk);
        enable = 0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R11 cs_n rises on disable", cs_n, 1);
        chk(sck == 1'b1, "R11 sck idle on disable", sck, 1);
        repeat (100) @(negedge clk);
        chk(rx_empty == 1'b1, "R11 aborted frame stores nothing", rx_empty, 1);
        cfg_cpol = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && rx_empty == 1'b1, "R1 state after reset", {cs_n, rx_empty}, 2'b11);
        t_frame(0, 0, 0, 4'd7,  16'h00B4);
        t_frame(0, 1, 0, 4'd7,  16'h0069);
        t_frame(1, 0, 1, 4'd7,  16'h00C3);
        t_frame(1, 1, 1, 4'd15, 16'hA5F0);
        t_frame(0, 1, 0, 4'd4,  16'hFF16);
        t_timing();
        t_flags();
        t_stall();
        t_fifo_full();
        t_enable();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule